// File: doc/BRIEF.md
# Bus Target Response Sequencer

This block is the target-side control engine for a shared 32-bit bus that carries address and data on the same wires. It watches the bus control lines and captures the address and the 4-bit command code in the one cycle in which the initiator presents them. It then decides whether the transaction belongs to it. A memory command is claimed when the address falls inside a parameterised window. A configuration command is claimed only while the slot-select input is high. The block answers with an active-low device-select strobe at a programmable decode speed, paces the data phases with its ready and stop strobes, and produces even parity one cycle behind the data it covers.

A small register array stands in for the storage behind the target. Writes honour the per-byte lane enables. Reads always return the full 32-bit word. A burst advances one word per completed data phase. The block disconnects, asserting stop together with ready, on the last word of its window. It also applies the bus timing rules: a turnaround cycle before read data, a minimum of medium decode speed after a back-to-back transaction that belonged to another target, and one cycle of driving the strobes high before releasing them.

Top module: `tgt_seq`

## Requirements
- R1: The address, command and slot-select are captured on the first clock edge at which the bus-cycle strobe is seen low after being high. Any later value on the address/data or command/byte-enable lines does not change the decode.
- R2: With decode speed fast, medium or slow, device-select is first sampled low at the 1st, 2nd or 3rd clock edge after the address edge. Ready is never asserted without device-select.
- R3: For a read (command bit 0 equal to 0), ready is never sampled low before the 2nd edge after the address edge, even at fast decode speed. Read data is driven only while ready is offered.
- R4: Fast decode is used only when the edge before the address edge saw the bus idle (bus-cycle and initiator-ready both high), or when the previous transaction on the bus was claimed by this target. Otherwise the decode is at least medium.
- R5: Configuration read (1010) and configuration write (1011) are claimed only while slot-select is high at the address edge. The word index is taken from address bits [5:2].
- R6: Memory commands are claimed only inside the window. These are read 0110, write 0111, read-multiple 1100, read-line 1110 and write-and-invalidate 1111. I/O commands (0010, 0011), the dual-address command (1101) and other codes are never claimed, and their write data changes no stored word.
- R7: On a write data phase, each byte lane whose active-low enable (bit n for bits 8n+7:8n) is 0 is updated. A phase with all four enables high changes nothing, but the next phase still goes to the next word.
- R8: A read burst returns consecutive words starting at the decoded index, with all 32 bits, whatever the byte enables are.
- R9: On the last word of the window, stop is asserted together with ready. If the initiator ends in that same phase, the transaction ends there with no extra cycle. Otherwise ready is withdrawn and stop is held until the bus-cycle strobe is seen high, and no further word is written.
- R10: The parity output, enabled one cycle after read data is driven, makes the count of ones over address/data, command/byte-enable and parity even for the previous cycle.
- R11: After reset and when idle, the control strobes and the data drivers are released. After a transaction ends, the strobes are driven high for exactly one cycle and then released.
- R12: Command bit 0 selects write (1) or read (0) for every claimed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Bus-cycle strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Slot select for configuration commands |
| cbe_n | input | 4 | Command in the address cycle, active-low byte enables in data cycles |
| ad_in | input | 32 | Address/data as seen on the bus |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| ctl_oe | output | 1 | Enable for devsel_n, trdy_n and stop_n |
| par | output | 1 | Even parity for the previous cycle |
| par_oe | output | 1 | Enable for par |

## Verification
The main decode is tried with a fast target and a slow target on one bus. Each is reached from an idle bus, back-to-back after the other target, and back-to-back after itself. This separates the decode speed from the back-to-back fallback. Write bursts mix full, partial and empty byte-enable patterns, and read bursts use empty enables. Together these separate lane masking from address advance, and show that reads ignore the enables. Unclaimable patterns cover I/O commands, the dual-address command, an address outside the window and configuration without slot-select, each followed by a read-back. Bursts that start on the last window word show both the disconnect that ends with the initiator and the one that forces an extra stop cycle.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MED  = 2'd1,
    SPD_SLOW = 2'd2
  } speed_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_STOPW,
    ST_TURN
  } seq_st_e;

  // Memory command codes that this target may claim inside its window.
  function automatic logic cmd_is_mem(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  // Configuration read and write.
  function automatic logic cmd_is_cfg(input logic [3:0] c);
    return (c == 4'b1010) || (c == 4'b1011);
  endfunction

  // Bit 0 low means data flows from target to initiator.
  function automatic logic cmd_is_read(input logic [3:0] c);
    return ~c[0];
  endfunction

  // Byte-lane merge with active-low lane enables.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  en_n);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = en_n[b] ? old_w[8*b +: 8] : new_w[8*b +: 8];
    return r;
  endfunction

  // Even parity bit over 36 bus bits.
  function automatic logic even_par(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

  // Claim latency in edges after the address edge, with the back-to-back rule.
  function automatic logic [1:0] claim_lat(input speed_e spd, input logic fast_ok);
    if (spd == SPD_FAST && !fast_ok) return 2'd1;
    return 2'(spd);
  endfunction

endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
  import tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          WIN_BYTES = 64
) (
  input  logic [31:0]                    ad,
  input  logic [3:0]                     cmd,
  input  logic                           idsel,
  output logic                           claim,
  output logic                           is_rd,
  output logic [$clog2(WIN_BYTES)-3:0]   idx
);
  localparam int AW = $clog2(WIN_BYTES);

  logic hit;
  logic unused_low;

  assign unused_low = &{1'b0, ad[1:0]};
  assign hit   = (ad[31:AW] == BASE_ADDR[31:AW]);
  assign claim = (cmd_is_mem(cmd) && hit) || (cmd_is_cfg(cmd) && idsel);
  assign is_rd = cmd_is_read(cmd);
  assign idx   = ad[AW-1:2];

endmodule

// File: rtl/tgt_store.sv
module tgt_store
  import tgt_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be_n,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [WORDS-1:0][31:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= lane_merge(mem_q[wr_idx], wr_data, wr_be_n);
    end
  end

  assign rd_data = mem_q[rd_idx];

  // R7: a data phase with every lane disabled leaves the array untouched
  p_noop_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_be_n)) |=> $stable(mem_q));

endmodule

// File: rtl/tgt_parity.sv
module tgt_parity
  import tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe_n,
  input  logic        ad_drv,
  output logic        par,
  output logic        par_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= even_par(ad, cbe_n);
      par_oe <= ad_drv;
    end
  end

  // R10: parity trails the covered cycle by one clock and makes the total even
  p_par_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((^{par, $past(ad), $past(cbe_n)}) == 1'b0));

  // R10: parity is enabled only right after read data was driven
  p_par_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ad_drv |=> par_oe);

endmodule

// File: rtl/tgt_seq.sv
module tgt_seq
  import tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          WIN_BYTES = 64,
  parameter speed_e      SPEED     = SPD_FAST
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe,
  output logic        par,
  output logic        par_oe
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int IW    = $clog2(WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  seq_st_e       st;
  logic [1:0]    ecnt, ldev, ltrdy;
  logic [IW-1:0] idx, nxt_idx, dec_idx, rd_sel;
  logic          rd_q, last_me, prev_frame_n, prev_idle;
  logic          dec_claim, dec_rd;
  logic [31:0]   rd_data;

  // named events for checking
  logic       addr_phase, addr_evt, fast_ok, xfer, wr_en;
  logic [1:0] lat_dev_w, lat_trdy_w;

  tgt_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) u_dec (
    .ad(ad_in), .cmd(cbe_n), .idsel(idsel),
    .claim(dec_claim), .is_rd(dec_rd), .idx(dec_idx)
  );

  assign addr_phase = prev_frame_n && !frame_n && (st == ST_IDLE || st == ST_TURN);
  assign addr_evt   = addr_phase && dec_claim;
  assign fast_ok    = prev_idle || last_me;
  assign lat_dev_w  = claim_lat(SPEED, fast_ok);
  assign lat_trdy_w = (dec_rd && lat_dev_w == 2'd0) ? 2'd1 : lat_dev_w;
  assign xfer       = (st == ST_DATA) && !irdy_n && !trdy_n;
  assign wr_en      = xfer && !rd_q;
  assign nxt_idx    = idx + 1'b1;
  assign rd_sel     = addr_evt ? dec_idx : (xfer ? nxt_idx : idx);

  tgt_store #(.WORDS(WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_data(ad_in), .wr_be_n(cbe_n), .rd_idx(rd_sel), .rd_data(rd_data)
  );

  tgt_parity u_par (
    .clk(clk), .rst_n(rst_n), .ad(ad_out), .cbe_n(cbe_n),
    .ad_drv(ad_oe), .par(par), .par_oe(par_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      ecnt         <= '0;
      ldev         <= '0;
      ltrdy        <= '0;
      idx          <= '0;
      rd_q         <= 1'b0;
      last_me      <= 1'b0;
      prev_frame_n <= 1'b1;
      prev_idle    <= 1'b1;
      devsel_n     <= 1'b1;
      trdy_n       <= 1'b1;
      stop_n       <= 1'b1;
      ctl_oe       <= 1'b0;
      ad_oe        <= 1'b0;
      ad_out       <= '0;
    end else begin
      prev_frame_n <= frame_n;
      prev_idle    <= frame_n & irdy_n;
      if (addr_phase) last_me <= dec_claim;

      case (st)
        ST_IDLE, ST_TURN: begin
          if (addr_evt) begin
            ctl_oe <= 1'b1;
            rd_q   <= dec_rd;
            idx    <= dec_idx;
            ldev   <= lat_dev_w;
            ltrdy  <= lat_trdy_w;
            ecnt   <= 2'd1;
            if (lat_dev_w == 2'd0) devsel_n <= 1'b0;
            if (lat_trdy_w == 2'd0) begin
              trdy_n <= 1'b0;
              stop_n <= (dec_idx != LAST_IDX);
              ad_oe  <= dec_rd;
              ad_out <= rd_data;
              st     <= ST_DATA;
            end else begin
              st <= ST_WAIT;
            end
          end else begin
            ctl_oe <= 1'b0;
            st     <= ST_IDLE;
          end
        end

        ST_WAIT: begin
          if (frame_n && irdy_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            st       <= ST_TURN;
          end else begin
            ecnt <= ecnt + 2'd1;
            if (ecnt == ldev) devsel_n <= 1'b0;
            if (ecnt == ltrdy) begin
              trdy_n <= 1'b0;
              stop_n <= (idx != LAST_IDX);
              ad_oe  <= rd_q;
              ad_out <= rd_data;
              st     <= ST_DATA;
            end
          end
        end

        ST_DATA: begin
          if (xfer) begin
            idx <= nxt_idx;
            if (frame_n) begin
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              stop_n   <= 1'b1;
              ad_oe    <= 1'b0;
              st       <= ST_TURN;
            end else if (!stop_n) begin
              trdy_n <= 1'b1;
              ad_oe  <= 1'b0;
              st     <= ST_STOPW;
            end else begin
              stop_n <= (nxt_idx != LAST_IDX);
              ad_out <= rd_data;
            end
          end
        end

        ST_STOPW: begin
          if (frame_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            st       <= ST_TURN;
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: ready only inside a claimed transaction
  p_trdy_has_devsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  // R3: no ready in the cycle after the address of a read
  p_read_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && dec_rd) |=> trdy_n);

  // R3: read data is driven only while ready is offered
  p_ad_with_trdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n);

  // R4: back-to-back after another target never claims fast
  p_b2b_medium_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && !fast_ok) |=> devsel_n);

  // R5: configuration commands need slot select
  p_cfg_idsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && cmd_is_cfg(cbe_n) && !idsel) |=> (st == ST_IDLE));

  // R9: while waiting out a disconnect, stop holds and ready is withdrawn
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOPW) |-> (trdy_n && !stop_n && !devsel_n));

  // R11: the final transfer is followed by one cycle of driven-high strobes
  p_end_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> (devsel_n && trdy_n && stop_n && ctl_oe));

endmodule

// File: tb/sim_tgt_seq.sv
`timescale 1ns/1ps
module sim_tgt_seq;
  import tgt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel0 = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic idsel1;
  assign idsel1 = 1'b0;

  logic [31:0] ad_out_0, ad_out_1;
  logic ad_oe_0, devsel_n_0, trdy_n_0, stop_n_0, ctl_oe_0, par_0, par_oe_0;
  logic ad_oe_1, devsel_n_1, trdy_n_1, stop_n_1, ctl_oe_1, par_1, par_oe_1;

  always #2 clk = ~clk;  // 250 MHz

  tgt_seq #(.BASE_ADDR(32'h0000_1000), .WIN_BYTES(64), .SPEED(SPD_FAST)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel0),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out_0), .ad_oe(ad_oe_0),
    .devsel_n(devsel_n_0), .trdy_n(trdy_n_0), .stop_n(stop_n_0), .ctl_oe(ctl_oe_0),
    .par(par_0), .par_oe(par_oe_0));

  tgt_seq #(.BASE_ADDR(32'h0000_2000), .WIN_BYTES(64), .SPEED(SPD_SLOW)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel1),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out_1), .ad_oe(ad_oe_1),
    .devsel_n(devsel_n_1), .trdy_n(trdy_n_1), .stop_n(stop_n_1), .ctl_oe(ctl_oe_1),
    .par(par_1), .par_oe(par_oe_1));

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  logic [31:0] wd [8];
  logic [31:0] rdv [8];
  logic [3:0]  wb [8];
  int dev_e, trdy_e, stop_e, end_e, ndone;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // R10: parity monitor, even over the previous cycle's bus bits
  logic stash0 = 1'b0, stash1 = 1'b0;
  always begin
    @(negedge clk); #1;
    if (rst_n && par_oe_0) chk("R10", "parity u0", {31'b0, par_0}, {31'b0, stash0});
    if (rst_n && par_oe_1) chk("R10", "parity u1", {31'b0, par_1}, {31'b0, stash1});
    stash0 = ^{ad_out_0, cbe_n};
    stash1 = ^{ad_out_1, cbe_n};
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; idsel0 = 1'b0; cbe_n = 4'hF;
    end
  endtask

  // One initiator transaction; edge numbers counted from the address edge (0).
  task automatic do_tx(input bit tsel, input logic [3:0] cmd, input logic [31:0] addr,
                       input logic ids, input int nph);
    bit rdc, stopping;
    int ph;
    logic dv, tr, sp;
    logic [31:0] ado;
    rdc = !cmd[0];
    stopping = 0; ph = 0;
    dev_e = -1; trdy_e = -1; stop_e = -1; end_e = -1; ndone = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel0 = ids;
    for (int e = 1; e <= 20; e++) begin
      @(negedge clk);
      dv  = tsel ? devsel_n_1 : devsel_n_0;
      tr  = tsel ? trdy_n_1   : trdy_n_0;
      sp  = tsel ? stop_n_1   : stop_n_0;
      ado = tsel ? ad_out_1   : ad_out_0;
      if (!dv && dev_e < 0) dev_e = e;
      if (!tr && trdy_e < 0) trdy_e = e;
      if (!sp && stop_e < 0) stop_e = e;
      idsel0 = 1'b0;
      if (stopping || (dev_e < 0 && e >= 5)) begin
        frame_n = 1'b1; irdy_n = 1'b0; end_e = e;
        break;
      end
      irdy_n  = 1'b0;
      frame_n = (ph == nph - 1);
      cbe_n   = wb[ph];
      ad_in   = rdc ? (32'hC3C3_0000 + 32'(e)) : wd[ph];
      if (!tr) begin
        if (rdc) rdv[ph] = ado;
        ndone++;
        if (frame_n) begin
          end_e = e;
          break;
        end
        if (!sp) stopping = 1;
        ph++;
      end
    end
  endtask

  task automatic set_be(input logic [3:0] v);
    for (int i = 0; i < 8; i++) wb[i] = v;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11", "reset devsel_n", {31'b0, devsel_n_0}, 32'd1);
    chk("R11", "reset trdy_n", {31'b0, trdy_n_0}, 32'd1);
    chk("R11", "reset stop_n", {31'b0, stop_n_0}, 32'd1);
    chk("R11", "reset ctl_oe", {31'b0, ctl_oe_0}, 32'd0);
    chk("R11", "reset ad_oe/par_oe", {30'b0, ad_oe_0, par_oe_0}, 32'd0);
  endtask

  task automatic t_write_fast();
    set_be(4'h0);
    wd[0] = 32'h1111_1111; wd[1] = 32'h2222_2222;
    do_tx(0, 4'b0111, 32'h0000_1008, 1'b0, 2);
    chk("R2", "fast write devsel edge", 32'(dev_e), 32'd1);
    chk("R12", "write ready edge", 32'(trdy_e), 32'd1);
    chk("R12", "write phases", 32'(ndone), 32'd2);
    idle(2);
  endtask

  task automatic t_read_fast();
    set_be(4'b0111);  // looks like a write command; must not matter (R1)
    do_tx(0, 4'b0110, 32'h0000_1008, 1'b0, 2);
    chk("R2", "fast read devsel edge", 32'(dev_e), 32'd1);
    chk("R3", "read turnaround ready edge", 32'(trdy_e), 32'd2);
    chk("R1", "read word0 after AD change", rdv[0], 32'h1111_1111);
    chk("R8", "read word1", rdv[1], 32'h2222_2222);
    @(negedge clk);
    chk("R11", "strobes high after end", {29'b0, devsel_n_0, trdy_n_0, stop_n_0}, 32'd7);
    chk("R11", "strobes still driven", {31'b0, ctl_oe_0}, 32'd1);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    chk("R11", "strobes released", {31'b0, ctl_oe_0}, 32'd0);
    idle(1);
  endtask

  task automatic t_bytes();
    set_be(4'h0);
    wd[0] = 32'hAAAA_AAAA;
    do_tx(0, 4'b1111, 32'h0000_1010, 1'b0, 1);
    idle(1);
    wb[0] = 4'b1010; wd[0] = 32'h1122_3344;
    do_tx(0, 4'b0111, 32'h0000_1010, 1'b0, 1);
    idle(1);
    wb[0] = 4'hF; wd[0] = 32'hFFFF_FFFF;
    wb[1] = 4'h0; wd[1] = 32'h5555_5555;
    do_tx(0, 4'b0111, 32'h0000_1018, 1'b0, 2);
    idle(1);
    set_be(4'hF);
    do_tx(0, 4'b1100, 32'h0000_1010, 1'b0, 4);
    chk("R7", "partial lanes", rdv[0], 32'hAA22_AA44);
    chk("R12", "read-multiple word5", rdv[1], 32'h0000_0000);
    chk("R7", "empty lanes no change", rdv[2], 32'h0000_0000);
    chk("R7", "address advanced", rdv[3], 32'h5555_5555);
    chk("R8", "burst length", 32'(ndone), 32'd4);
    idle(2);
  endtask

  task automatic t_b2b();
    set_be(4'h0);
    wd[0] = 32'h0BAD_F00D;
    do_tx(1, 4'b0111, 32'h0000_2000, 1'b0, 1);
    chk("R2", "slow devsel edge", 32'(dev_e), 32'd3);
    do_tx(0, 4'b0110, 32'h0000_1008, 1'b0, 1);
    chk("R4", "b2b other target devsel", 32'(dev_e), 32'd2);
    chk("R4", "b2b other target ready", 32'(trdy_e), 32'd2);
    chk("R8", "b2b data", rdv[0], 32'h1111_1111);
    do_tx(0, 4'b0110, 32'h0000_100C, 1'b0, 1);
    chk("R4", "b2b same target devsel", 32'(dev_e), 32'd1);
    chk("R3", "b2b same target ready", 32'(trdy_e), 32'd2);
    chk("R8", "b2b same data", rdv[0], 32'h2222_2222);
    idle(2);
  endtask

  task automatic t_cfg();
    set_be(4'h0);
    do_tx(0, 4'b1010, 32'h0000_0008, 1'b0, 1);
    chk("R5", "cfg without select", 32'(dev_e), 32'hFFFF_FFFF);
    idle(2);
    do_tx(0, 4'b1010, 32'h0000_0008, 1'b1, 1);
    chk("R5", "cfg with select", 32'(dev_e), 32'd1);
    chk("R5", "cfg data", rdv[0], 32'h1111_1111);
    idle(2);
  endtask

  task automatic t_unsup();
    set_be(4'h0);
    wd[0] = 32'h9999_9999;
    do_tx(0, 4'b0011, 32'h0000_1014, 1'b0, 1);
    chk("R6", "io write unclaimed", 32'(dev_e), 32'hFFFF_FFFF);
    idle(2);
    do_tx(0, 4'b1101, 32'h0000_1014, 1'b0, 1);
    chk("R6", "dual address unclaimed", 32'(dev_e), 32'hFFFF_FFFF);
    idle(2);
    do_tx(0, 4'b0110, 32'h0000_3000, 1'b0, 1);
    chk("R6", "outside window unclaimed", 32'(dev_e), 32'hFFFF_FFFF);
    idle(2);
    do_tx(0, 4'b0110, 32'h0000_1014, 1'b0, 1);
    chk("R6", "io write ignored", rdv[0], 32'h0000_0000);
    idle(2);
  endtask

  task automatic t_disc();
    set_be(4'h0);
    wd[0] = 32'h7777_7777; wd[1] = 32'h8888_8888; wd[2] = 32'h9999_9999;
    do_tx(0, 4'b0111, 32'h0000_103C, 1'b0, 3);
    chk("R9", "stop with first ready", 32'(stop_e), 32'(trdy_e));
    chk("R9", "one word moved", 32'(ndone), 32'd1);
    chk("R9", "extra stop cycle", 32'(end_e), 32'(trdy_e + 1));
    idle(2);
    do_tx(0, 4'b0110, 32'h0000_1000, 1'b0, 1);
    chk("R9", "no wrap write", rdv[0], 32'h0000_0000);
    idle(2);
    do_tx(0, 4'b0110, 32'h0000_103C, 1'b0, 1);
    chk("R9", "aligned stop edge", 32'(stop_e), 32'd2);
    chk("R9", "aligned end edge", 32'(end_e), 32'd2);
    chk("R9", "last word data", rdv[0], 32'h7777_7777);
    @(negedge clk);
    chk("R9", "no extra stop cycle", {31'b0, stop_n_0}, 32'd1);
    frame_n = 1'b1; irdy_n = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_fast();
    t_read_fast();
    t_bytes();
    t_b2b();
    t_cfg();
    t_unsup();
    t_disc();
    finish_run();
  end

endmodule